// File: doc/BRIEF.md
# Sequencer State Word Loader

This block feeds a sequencing state machine with its current state definition. The state table lives only in a byte-wide nonvolatile store with a fixed read latency. The block keeps no resident copy of that table. It reads the definition it needs, 64 bits at a time, whenever the machine moves on.

After reset the block loads slot 0. It then waits for the condition evaluator to report that the exit condition of the current state is met. At that point it decodes the next slot number from a field of the current word and fetches that slot. Every load takes the same parameterised number of cycles, whatever the store latency. The nominal setting is about 10 µs of clock cycles.

The last slot is reserved. If a word names the reserved slot as its successor, the load is refused and an error flag is raised. Edits written to the store through the write port take effect the next time the edited slot is loaded.

Top module: `seq_state_loader`

## Requirements
- R1: While reset is asserted: `busy` is 1; `word_valid`, `idx_err`, `state_word` and `state_idx` are all 0.
- R2: After reset is released, slot 0 is loaded. `busy` stays 1 until the (LOAD_CYCLES+1)th rising edge after release. At that edge `busy` drops, `word_valid` goes high for exactly one cycle, and `state_idx` becomes 0.
- R3: The word of slot s is built from store bytes s*8 to s*8+7. The lowest address is placed in bits 7:0 and the highest in bits 63:56.
- R4: If `cond_met` is 1 in a cycle with `busy` at 0, the successor slot is taken from `state_word[61:56]` (NEXT_LSB = 56). `busy` rises at the next edge and drops LOAD_CYCLES edges after that. At that same edge `word_valid` pulses and the new word and index appear.
- R5: `cond_met` has no effect while `busy` is 1, including the last busy cycle. Holding it high during a load does not cause a second load.
- R6: If the successor field equals the reserved slot (63), an accepted `cond_met` sets `idx_err` at the next edge and no load starts. `busy` stays 0, and `state_word` and `state_idx` keep their values. `idx_err` stays set until reset.
- R7: A store write never changes the presented `state_word`. Bytes written to a slot appear in `state_word` the next time that slot is loaded.
- R8: A `cond_met` in the same cycle as the `word_valid` pulse is accepted and starts the next load.
- R9: `state_word` and `state_idx` change only at the edge that raises `word_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_met | input | 1 | Exit condition of the current state is satisfied |
| wr_en | input | 1 | Write one byte into the state store |
| wr_addr | input | 9 | Byte address of the store write |
| wr_data | input | 8 | Byte to be written |
| state_word | output | 64 | Active state definition |
| state_idx | output | 6 | Slot number of the active state |
| busy | output | 1 | A state load is in progress |
| word_valid | output | 1 | One-cycle pulse: new word is in place |
| idx_err | output | 1 | Sticky: a successor pointed at the reserved slot |

## Verification
Two events can fall in the same cycle: the completion of a load (the `word_valid` pulse) and the acceptance of a new exit condition. The bench holds `cond_met` high through an entire load and lowers it exactly in the valid cycle. This shows that the last busy cycle is ignored. In a second load it raises `cond_met` exactly in the valid cycle. There it expects a further load of exactly LOAD_CYCLES busy cycles that ends on the slot named by the freshly committed word.

// File: rtl/seqld_pkg.sv
package seqld_pkg;

    typedef enum logic [1:0] {
        PH_BOOT = 2'd0,
        PH_LOAD = 2'd1,
        PH_RUN  = 2'd2
    } ld_phase_e;

endpackage

// File: rtl/seqld_store.sv
module seqld_store #(
    parameter int DEPTH = 512,
    parameter int LAT   = 2,
    parameter int TAG_W = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag_o,
    output logic [7:0]       rd_data
);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [7:0]       data;
    } rd_stage_t;

    logic [7:0] mem_q [DEPTH];
    rd_stage_t  pipe_d [LAT];
    rd_stage_t  pipe_q [LAT];

    // array writes bypass the two-process split: no reset on storage
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        pipe_d[0].vld  = rd_en;
        pipe_d[0].tag  = rd_tag;
        pipe_d[0].data = rd_en ? mem_q[rd_addr] : 8'h00;
        for (int i = 1; i < LAT; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < LAT; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    assign rd_vld   = pipe_q[LAT-1].vld;
    assign rd_tag_o = pipe_q[LAT-1].tag;
    assign rd_data  = pipe_q[LAT-1].data;

endmodule

// File: rtl/seqld_fetch.sv
module seqld_fetch #(
    parameter int WORD_BYTES  = 8,
    parameter int SLOT_W      = 6,
    parameter int RD_LAT      = 2,
    parameter int LOAD_CYCLES = 2000,
    localparam int BYTE_W     = $clog2(WORD_BYTES),
    localparam int WORD_W     = WORD_BYTES * 8,
    localparam int CNT_W      = $clog2(LOAD_CYCLES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [SLOT_W-1:0]        start_slot,
    output logic                     rd_en,
    output logic [SLOT_W+BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0]        rd_tag,
    input  logic                     rd_vld,
    input  logic [BYTE_W-1:0]        rd_tag_in,
    input  logic [7:0]               rd_data,
    output logic                     active,
    output logic                     done,
    output logic [WORD_W-1:0]        word
);

    if (LOAD_CYCLES < WORD_BYTES + RD_LAT + 2) begin : g_bad_delay
        $error("LOAD_CYCLES too short for byte reads plus read latency");
    end

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
        logic [WORD_W-1:0] asm_word;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        done    = f_q.active && (f_q.cnt == CNT_W'(LOAD_CYCLES - 1));
        rd_en   = f_q.active && (f_q.cnt < CNT_W'(WORD_BYTES));
        rd_tag  = f_q.cnt[BYTE_W-1:0];
        rd_addr = {f_q.slot, f_q.cnt[BYTE_W-1:0]};

        if (rd_vld) begin
            f_d.asm_word[{rd_tag_in, 3'b000} +: 8] = rd_data;
        end

        if (f_q.active) begin
            if (done) begin
                f_d.active = 1'b0;
            end else begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
        end else if (start) begin
            f_d.active = 1'b1;
            f_d.cnt    = '0;
            f_d.slot   = start_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign active = f_q.active;
    assign word   = f_q.asm_word;

    AST_RETURN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> f_q.active); // R3

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !f_q.active) |=> (f_q.active && f_q.cnt == '0)); // R4

endmodule

// File: rtl/seqld_next_decode.sv
module seqld_next_decode #(
    parameter int WORD_W        = 64,
    parameter int SLOT_W        = 6,
    parameter int NEXT_LSB      = 56,
    parameter int RESERVED_SLOT = 63
) (
    input  logic [WORD_W-1:0] cur_word,
    output logic [SLOT_W-1:0] next_slot,
    output logic              next_reserved
);

    always_comb begin
        next_slot     = cur_word[NEXT_LSB +: SLOT_W];
        next_reserved = (next_slot == SLOT_W'(RESERVED_SLOT));
    end

endmodule

// File: rtl/seq_state_loader.sv
module seq_state_loader
    import seqld_pkg::*;
#(
    parameter int SLOT_COUNT  = 64,
    parameter int WORD_BYTES  = 8,
    parameter int RD_LAT      = 2,
    parameter int LOAD_CYCLES = 2000,
    parameter int NEXT_LSB    = 56
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cond_met,
    input  logic                                      wr_en,
    input  logic [$clog2(SLOT_COUNT*WORD_BYTES)-1:0]  wr_addr,
    input  logic [7:0]                                wr_data,
    output logic [WORD_BYTES*8-1:0]                   state_word,
    output logic [$clog2(SLOT_COUNT)-1:0]             state_idx,
    output logic                                      busy,
    output logic                                      word_valid,
    output logic                                      idx_err
);

    localparam int SLOT_W        = $clog2(SLOT_COUNT);
    localparam int BYTE_W        = $clog2(WORD_BYTES);
    localparam int WORD_W        = WORD_BYTES * 8;
    localparam int DEPTH         = SLOT_COUNT * WORD_BYTES;
    localparam int AW            = $clog2(DEPTH);
    localparam int RESERVED_SLOT = SLOT_COUNT - 1;

    typedef struct packed {
        ld_phase_e         phase;
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] idx;
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              f_start;
    logic [SLOT_W-1:0] f_slot;
    logic              f_active;
    logic              f_done;
    logic [WORD_W-1:0] f_word;
    logic              rd_en;
    logic [AW-1:0]     rd_addr;
    logic [BYTE_W-1:0] rd_tag;
    logic              rd_vld;
    logic [BYTE_W-1:0] rd_tag_ret;
    logic [7:0]        rd_data;
    logic [SLOT_W-1:0] nxt_slot;
    logic              nxt_reserved;

    seqld_store #(
        .DEPTH (DEPTH),
        .LAT   (RD_LAT),
        .TAG_W (BYTE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_tag   (rd_tag),
        .rd_vld   (rd_vld),
        .rd_tag_o (rd_tag_ret),
        .rd_data  (rd_data)
    );

    seqld_fetch #(
        .WORD_BYTES  (WORD_BYTES),
        .SLOT_W      (SLOT_W),
        .RD_LAT      (RD_LAT),
        .LOAD_CYCLES (LOAD_CYCLES)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (f_start),
        .start_slot (f_slot),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_tag     (rd_tag),
        .rd_vld     (rd_vld),
        .rd_tag_in  (rd_tag_ret),
        .rd_data    (rd_data),
        .active     (f_active),
        .done       (f_done),
        .word       (f_word)
    );

    seqld_next_decode #(
        .WORD_W        (WORD_W),
        .SLOT_W        (SLOT_W),
        .NEXT_LSB      (NEXT_LSB),
        .RESERVED_SLOT (RESERVED_SLOT)
    ) u_decode (
        .cur_word      (c_q.word),
        .next_slot     (nxt_slot),
        .next_reserved (nxt_reserved)
    );

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        f_start   = 1'b0;
        f_slot    = c_q.slot;
        unique case (c_q.phase)
            PH_BOOT: begin
                f_start   = 1'b1;
                f_slot    = '0;
                c_d.slot  = '0;
                c_d.phase = PH_LOAD;
            end
            PH_LOAD: begin
                if (f_done) begin
                    c_d.word  = f_word;
                    c_d.idx   = c_q.slot;
                    c_d.valid = 1'b1;
                    c_d.phase = PH_RUN;
                end
            end
            PH_RUN: begin
                if (cond_met) begin
                    if (nxt_reserved) begin
                        c_d.err = 1'b1;
                    end else begin
                        f_start   = 1'b1;
                        f_slot    = nxt_slot;
                        c_d.slot  = nxt_slot;
                        c_d.phase = PH_LOAD;
                    end
                end
            end
            default: begin
                c_d.phase = PH_BOOT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.phase <= PH_BOOT;
        end else begin
            c_q <= c_d;
        end
    end

    assign state_word = c_q.word;
    assign state_idx  = c_q.idx;
    assign busy       = (c_q.phase != PH_RUN);
    assign word_valid = c_q.valid;
    assign idx_err    = c_q.err;

    AST_COMMIT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_valid) |-> $past(f_done)); // R2

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R2

    AST_NO_START_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        f_start |-> !f_active); // R5

    AST_ERR_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idx_err) |-> (!busy && $stable(state_idx) && $stable(state_word))); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err |=> idx_err); // R6

    AST_WORD_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> ($stable(state_word) && $stable(state_idx))); // R9

endmodule

// File: tb/seq_state_loader_tb.sv
module seq_state_loader_tb;

    localparam int L   = 24;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cond_met;
    logic        wr_en;
    logic [8:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [63:0] state_word;
    logic [5:0]  state_idx;
    logic        busy;
    logic        word_valid;
    logic        idx_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    seq_state_loader #(
        .SLOT_COUNT  (64),
        .WORD_BYTES  (8),
        .RD_LAT      (LAT),
        .LOAD_CYCLES (L),
        .NEXT_LSB    (56)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond_met   (cond_met),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .state_word (state_word),
        .state_idx  (state_idx),
        .busy       (busy),
        .word_valid (word_valid),
        .idx_err    (idx_err)
    );

    function automatic logic [63:0] mk(int s, int nxt, int salt);
        logic [63:0] w;
        for (int b = 0; b < 7; b++) begin
            w[b*8 +: 8] = 8'(s * 29 + b * 17 + salt * 5 + 3);
        end
        w[63:56] = {2'b10, 6'(nxt)};
        return w;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_byte(input int addr, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_slot(input int s, input logic [63:0] w);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 9'(s * 8 + b); wr_data = w[b*8 +: 8];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Called at a negedge right after the load trigger. mode 0: drop cond at
    // first sample; 1: hold cond until busy falls; 2: hold, then re-raise it
    // in the valid cycle. Returns the number of busy samples.
    task automatic measure_load(input int mode, output int n);
        n = 0;
        for (int k = 0; k < L + 20; k++) begin
            @(negedge clk);
            if (mode == 0 && k == 0) cond_met = 1'b0;
            if (busy) begin
                n++;
            end else begin
                cond_met = (mode == 2);
                break;
            end
        end
    endtask

    task automatic test_reset();
        chk("R1 busy in reset", 64'(busy), 64'd1);
        chk("R1 valid in reset", 64'(word_valid), 64'd0);
        chk("R1 err in reset", 64'(idx_err), 64'd0);
        chk("R1 word in reset", state_word, 64'd0);
        chk("R1 idx in reset", 64'(state_idx), 64'd0);
    endtask

    task automatic test_boot();
        int n;
        @(negedge clk);
        rst_n = 1'b1;
        measure_load(0, n);
        chk("R2 boot busy length", 64'(n), 64'(L));
        chk("R2 boot valid pulse", 64'(word_valid), 64'd1);
        chk("R2 boot index", 64'(state_idx), 64'd0);
        chk("R3 boot word byte order", state_word, mk(0, 5, 0));
        @(negedge clk);
        chk("R2 valid single cycle", 64'(word_valid), 64'd0);
    endtask

    task automatic test_hold_cond();
        int n;
        cond_met = 1'b1;
        measure_load(1, n);
        chk("R4 load length", 64'(n), 64'(L));
        chk("R4 new index", 64'(state_idx), 64'd5);
        chk("R4 new word", state_word, mk(5, 12, 0));
        chk("R4 valid pulse", 64'(word_valid), 64'd1);
        repeat (3) @(negedge clk);
        chk("R5 no extra load busy", 64'(busy), 64'd0);
        chk("R5 no extra load idx", 64'(state_idx), 64'd5);
    endtask

    task automatic test_store_edit();
        int n;
        logic [63:0] held;
        held = state_word;
        write_byte(5 * 8 + 2, 8'h5A);
        write_slot(12, mk(12, 3, 7));
        repeat (2) @(negedge clk);
        chk("R7 write leaves word", state_word, held);
        chk("R9 word stable in run", 64'(state_idx), 64'd5);
        cond_met = 1'b1;
        measure_load(2, n);
        chk("R7 edited slot length", 64'(n), 64'(L));
        chk("R7 edited slot word", state_word, mk(12, 3, 7));
        chk("R7 edited slot idx", 64'(state_idx), 64'd12);
        measure_load(0, n);
        chk("R8 cond in valid cycle accepted", 64'(n), 64'(L));
        chk("R8 chained idx", 64'(state_idx), 64'd3);
        chk("R8 chained word", state_word, mk(3, 63, 0));
    endtask

    task automatic test_reserved();
        int nb;
        logic [63:0] held;
        held = state_word;
        @(negedge clk);
        cond_met = 1'b1;
        @(negedge clk);
        cond_met = 1'b0;
        chk("R6 err raised", 64'(idx_err), 64'd1);
        chk("R6 no load", 64'(busy), 64'd0);
        chk("R6 idx held", 64'(state_idx), 64'd3);
        nb = 0;
        for (int k = 0; k < L + 4; k++) begin
            @(negedge clk);
            if (k == 2) cond_met = 1'b1;
            if (k == 3) cond_met = 1'b0;
            if (busy) nb++;
        end
        chk("R6 never busy after error", 64'(nb), 64'd0);
        chk("R6 err sticky", 64'(idx_err), 64'd1);
        chk("R9 word held after error", state_word, held);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 err cleared by reset", 64'(idx_err), 64'd0);
        chk("R1 busy after reset", 64'(busy), 64'd1);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; cond_met = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        write_slot(0,  mk(0, 5, 0));
        write_slot(5,  mk(5, 12, 0));
        write_slot(12, mk(12, 0, 0));
        write_slot(3,  mk(3, 63, 0));
        test_reset();
        test_boot();
        test_hold_cond();
        test_store_edit();
        test_reserved();
        finished = 1'b1;
        finish_run();
    end

endmodule